// File: doc/BRIEF.md
# Selectable Binary Clock Divider

This block produces one test clock from two candidates: an external clock pin and a local fast source clock. The source clock drives a ripple chain of divide-by-two toggle stages, which yields taps at one half, one quarter, and so on down to one sixty-fourth of the source rate. A 3-bit select code picks the output from among the external clock, the undivided source and some of the divided taps.

The select mapping is deliberately irregular. Code 000 bypasses the chain and forwards the external clock. Code 100 forwards the source unchanged. The other codes pick specific power-of-two taps. The /8 tap exists in the chain, but no select code reaches it. An active-low asynchronous reset clears every divider stage, so any divided selection is held low while reset is asserted. With a nominal 50 MHz source, codes 001 to 111 give 25, 25, 12.5, 50, 3.13, 1.56 and 0.78 MHz.

Top module: `clk_div_sel`

## Requirements
- R1: With select 000, `clk_o` follows `ext_clk_i`, whatever the reset or the divider state.
- R2: With select 001 or select 010, `clk_o` has a period of 2 source periods.
- R3: With select 011, `clk_o` has a period of 4 source periods. With select 100, `clk_o` follows `src_clk_i` (a period of 1 source period).
- R4: Selects 101, 110 and 111 give `clk_o` periods of 16, 32 and 64 source periods. In general, code c in 101..111 gives 2^(c-1).
- R5: While `rst_ni` is low, every divided tap is held low, so `clk_o` stays low for any select other than 000 and 100. Asserting reset forces a divided output low without waiting for a clock edge.
- R6: No select code produces a period of 8 source periods.
- R7: After reset is released, every divided tap first rises on the first rising edge of `src_clk_i`. Every divided output has a 50% duty cycle.
- R8: Each stage after the first toggles exactly when the stage before it rises, so successive output periods are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Fast local source clock feeding the divider chain |
| ext_clk_i | input | 1 | External clock, forwarded on select 000 |
| sel_i | input | 3 | Output clock select code |
| rst_ni | input | 1 | Active-low asynchronous reset of all divider stages |
| clk_o | output | 1 | Selected test clock |

## Verification
A stage stuck or wrongly toggled changes the period or the duty cycle of every selection that uses that stage or any later stage. This shows within one output period, which is at most 64 source cycles. A wrong decoder entry shows at once as a wrong period for that code, or as the /8 ratio appearing. A reset path that fails to clear shows as output activity during reset, or as a tap that does not rise on the first source edge after release.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_EXT = 3'b000,
    SEL_D2A = 3'b001,
    SEL_D2B = 3'b010,
    SEL_D4  = 3'b011,
    SEL_SRC = 3'b100,
    SEL_D16 = 3'b101,
    SEL_D32 = 3'b110,
    SEL_D64 = 3'b111
  } clk_sel_e;

  // Number of halvings for a code; 0 means undivided (and is unused for SEL_EXT).
  function automatic int unsigned sel_to_shift(logic [SEL_W-1:0] s);
    case (s)
      SEL_D2A, SEL_D2B: return 1;
      SEL_D4:           return 2;
      SEL_D16:          return 4;
      SEL_D32:          return 5;
      SEL_D64:          return 6;
      default:          return 0;
    endcase
  endfunction
endpackage

// File: rtl/clk_div_stage.sv
module clk_div_stage (
  input  logic clk_i,
  input  logic rst_ni,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= ~q_o;
  end
endmodule

// File: rtl/clk_div_chain.sv
module clk_div_chain #(
  parameter int unsigned STAGES = 6
) (
  input  logic              src_clk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] tap_o
);
  logic [STAGES-1:0] stage_clk;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      assign stage_clk[k] = src_clk_i;
    end else begin : g_next
      assign stage_clk[k] = tap_o[k-1];
    end
    clk_div_stage i_stage (
      .clk_i (stage_clk[k]),
      .rst_ni(rst_ni),
      .q_o   (tap_o[k])
    );
  end

  assert_taps_clear_R5: assert property (@(posedge src_clk_i)
    !rst_ni |-> (tap_o == '0));

  assert_first_toggles_R7: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    1'b1 |=> (tap_o[0] != $past(tap_o[0])));

  for (genvar k = 1; k < STAGES; k++) begin : g_chk
    assert_ripple_R8: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> ((tap_o[k] != $past(tap_o[k])) == $rose(tap_o[k-1])));
  end
endmodule

// File: rtl/clk_div_pick.sv
module clk_div_pick
  import clk_div_pkg::*;
#(
  parameter int unsigned STAGES = 6
) (
  input  logic              ext_clk_i,
  input  logic              src_clk_i,
  input  logic [STAGES-1:0] tap_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              clk_o
);
  localparam int unsigned IDX_W = $clog2(STAGES + 1);

  logic [STAGES:0]    cand;
  logic [IDX_W-1:0]   idx;

  assign cand = {tap_i, src_clk_i};
  assign idx  = IDX_W'(sel_to_shift(sel_i));

  always_comb begin
    if (sel_i == SEL_EXT) clk_o = ext_clk_i;
    else                  clk_o = cand[idx];
  end
endmodule

// File: rtl/clk_div_sel.sv
module clk_div_sel
  import clk_div_pkg::*;
#(
  parameter int unsigned STAGES = 6
) (
  input  logic             src_clk_i,
  input  logic             ext_clk_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rst_ni,
  output logic             clk_o
);
  logic [STAGES-1:0] tap;

  clk_div_chain #(.STAGES(STAGES)) i_chain (
    .src_clk_i(src_clk_i),
    .rst_ni   (rst_ni),
    .tap_o    (tap)
  );

  clk_div_pick #(.STAGES(STAGES)) i_pick (
    .ext_clk_i(ext_clk_i),
    .src_clk_i(src_clk_i),
    .tap_i    (tap),
    .sel_i    (sel_i),
    .clk_o    (clk_o)
  );

  assert_ext_bypass_R1: assert property (@(negedge ext_clk_i)
    (sel_i == SEL_EXT) |-> clk_o);

  assert_src_pass_R3: assert property (@(negedge src_clk_i)
    (sel_i == SEL_SRC) |-> clk_o);

  assert_held_low_R5: assert property (@(negedge src_clk_i)
    (!rst_ni && sel_i != SEL_EXT && sel_i != SEL_SRC) |-> !clk_o);
endmodule

// File: tb/test_clk_div_sel.sv
`timescale 1ns/1ps
module test_clk_div_sel;
  localparam real SRC_T = 5.0;
  localparam real EXT_T = 14.0;

  logic       src_clk = 1'b0;
  logic       ext_clk = 1'b0;
  logic [2:0] sel = 3'b011;
  logic       rst_n = 1'b0;
  logic       clk_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  real seen [8];

  always #2.5 src_clk = ~src_clk;
  always #7.0 ext_clk = ~ext_clk;

  clk_div_sel i_clk_div_sel (
    .src_clk_i(src_clk),
    .ext_clk_i(ext_clk),
    .sel_i    (sel),
    .rst_ni   (rst_n),
    .clk_o    (clk_out)
  );

  task automatic chk_real(string req, real act, real exp);
    checks++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      errors++;
      $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real expect_period(int code);
    if (code == 0) return EXT_T;
    if (code == 4) return SRC_T;
    if (code == 1 || code == 2) return 2.0 * SRC_T;
    if (code == 3) return 4.0 * SRC_T;
    return SRC_T * real'(1 << (code - 1));
  endfunction

  task automatic measure(output real per, output real hi, output real per2);
    real t0, tn, t1, t2;
    repeat (2) @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out) tn = $realtime;
    @(posedge clk_out) t1 = $realtime;
    @(posedge clk_out) t2 = $realtime;
    per = t1 - t0;
    hi = tn - t0;
    per2 = t2 - t1;
  endtask

  initial begin
    int highs;
    real p, h, p2;
    // R5: divided selections held low during reset
    highs = 0;
    repeat (20) @(negedge src_clk) if (clk_out) highs++;
    chk_int("R5 reset sel=011 highs", highs, 0);
    sel = 3'b111;
    highs = 0;
    repeat (20) @(negedge src_clk) if (clk_out) highs++;
    chk_int("R5 reset sel=111 highs", highs, 0);

    // R7: first source edge after release raises every tap
    @(negedge src_clk) rst_n = 1'b1;
    @(posedge src_clk) #1;
    chk_int("R7 /64 tap high after first edge", int'(clk_out), 1);
    sel = 3'b011;
    #0.1;
    chk_int("R7 /4 tap high after first edge", int'(clk_out), 1);

    for (int c = 0; c < 8; c++) begin
      @(negedge src_clk) sel = 3'(c);
      measure(p, h, p2);
      seen[c] = p;
      case (c)
        0: chk_real("R1 ext period", p, expect_period(c));
        1, 2: chk_real("R2 /2 period", p, expect_period(c));
        3, 4: chk_real("R3 period", p, expect_period(c));
        default: chk_real("R4 period", p, expect_period(c));
      endcase
      if (c != 0 && c != 4) chk_real("R7 duty high time", h, p / 2.0);
      if (c == 7) chk_real("R8 second period equal", p2, p);
    end

    highs = 0;
    for (int c = 0; c < 8; c++)
      if (seen[c] > 8.0 * SRC_T - 0.01 && seen[c] < 8.0 * SRC_T + 0.01) highs++;
    chk_int("R6 codes giving /8", highs, 0);

    // R5: asynchronous clear mid-run
    @(negedge src_clk) sel = 3'b101;
    repeat (40) @(posedge src_clk);
    #1 rst_n = 1'b0;
    #0.5;
    chk_int("R5 async clear output", int'(clk_out), 0);
    highs = 0;
    repeat (10) @(negedge src_clk) if (clk_out) highs++;
    chk_int("R5 held low after clear", highs, 0);
    @(negedge src_clk) rst_n = 1'b1;
    @(negedge src_clk);
    chk_int("R7 /16 high after release", int'(clk_out), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule